// File: doc/BRIEF.md
# Reset and Sleep Sequencing Controller

This block decides when a motor driver's digital core is held in reset, when it sits in a low-power sleep state, and when step pulses and serial register accesses may pass. It takes a supply undervoltage flag, an external reset pin, an active-low sleep pin, the raw step input and a serial-access request. From these it produces a one-cycle register-clear pulse, a power-stage enable, a request for the analog circuits to enter low power, a gated step output, a gated serial-access output and a ready flag.

An undervoltage condition and the reset pin act alike. Sleep takes priority over both: while the sleep pin is low, reset requests are ignored. Once sleep is released, a reset that is still asserted takes effect on the next cycle. Two settle windows are counted in clock cycles, one after leaving reset and one after leaving sleep. Each lasts `CLK_HZ/1000` cycles, which is about 1 ms. Serial access stays open during sleep but is shut while reset is in effect.

Top module: `pwrseq_top`

## Requirements
- R1: When `uvFlag` or `resetPin` is high while `sleepN` is high at a clock edge, reset is in effect for the following cycle. During that cycle `powerEn`, `stepGate`, `serGate` and `ready` are all low.
- R2: `regClrPulse` is high for exactly one cycle: the first cycle of each period of reset in effect. This includes the first cycle after `sysRstN` is released, because the block starts up in reset.
- R3: `serGate` equals `serAccReq` in every cycle in which reset is not in effect, sleep included. It is low in every cycle in which reset is in effect.
- R4: When `sleepN` is low at a clock edge, the following cycle has `analogLowPwr` high and `powerEn`, `stepGate` and `ready` low.
- R5: While `sleepN` is low, `uvFlag` and `resetPin` have no effect: no `regClrPulse` is produced and serial access stays open. A reset request still held when `sleepN` returns high takes effect in the cycle after that edge.
- R6: After reset stops being in effect, `powerEn` and `ready` remain low for WAIT = `CLK_HZ/1000` further cycles. This reset wait keeps counting while sleep is active.
- R7: After sleep ends, `stepGate` and `ready` remain low for WAIT further cycles. `powerEn` may be high during this wait if no reset wait is pending.
- R8: `ready` is high only when reset is not in effect, sleep is not active, and neither wait is pending. `stepGate` equals `stepIn` AND `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the sequencer logic |
| uvFlag | input | 1 | Motor supply undervoltage indication, active high |
| resetPin | input | 1 | External reset request, active high |
| sleepN | input | 1 | Sleep request, active low |
| stepIn | input | 1 | Raw step input |
| serAccReq | input | 1 | Serial register access request |
| regClrPulse | output | 1 | One-cycle register/indexer clear on reset entry |
| powerEn | output | 1 | Power stage enable |
| analogLowPwr | output | 1 | Low-power request to the analog circuits |
| stepGate | output | 1 | Step input passed on to the indexer |
| serGate | output | 1 | Serial access passed on to the register file |
| ready | output | 1 | Fully functional: no reset, no sleep, no wait pending |

## Verification
The hardest case to reach is a reset request held across a sleep exit while an earlier reset wait is still counting. The correct result is a fresh clear pulse one cycle after `sleepN` rises, followed by a reload of the reset wait. The bench drives this sequence in a directed step. It then runs long random stretches in which the reset, undervoltage and sleep inputs toggle rarely and independently. Because they change so seldom, windows regularly expire, and in some runs they overlap: sleep starts inside a reset wait, or a reset arrives inside a sleep wait.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  // Strobes from the control section to the settle-timer datapath.
  typedef struct packed {
    logic holdRst;  // reset currently in effect: keep reset timer loaded
    logic holdSlp;  // sleep currently active: keep sleep timer loaded
  } seqStrobe_t;

  localparam int unsigned NUM_TIMERS = 2;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int unsigned WAIT = 8
) (
  input  logic       clk,
  input  logic       sysRstN,
  input  seqStrobe_t strobe,
  output logic       rstBusy,
  output logic       slpBusy
);
  localparam int unsigned CW = (WAIT < 1) ? 1 : $clog2(WAIT + 1);
  localparam logic [CW-1:0] WAIT_V = CW'(WAIT);

  logic [NUM_TIMERS-1:0] holdVec;
  logic [NUM_TIMERS-1:0] busyVec;

  assign holdVec = {strobe.holdSlp, strobe.holdRst};

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    // Timer 0 (reset) starts loaded: the block powers up in reset.
    localparam logic [CW-1:0] INIT_V = (i == 0) ? WAIT_V : '0;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) begin
        cnt <= INIT_V;
      end else if (holdVec[i]) begin
        cnt <= WAIT_V;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign busyVec[i] = (cnt != '0);
  end

  assign rstBusy = busyVec[0];
  assign slpBusy = busyVec[1];
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       uvFlag,
  input  logic       resetPin,
  input  logic       sleepN,
  input  logic       stepIn,
  input  logic       serAccReq,
  input  logic       rstBusy,
  input  logic       slpBusy,
  output seqStrobe_t strobe,
  output logic       regClrPulse,
  output logic       powerEn,
  output logic       analogLowPwr,
  output logic       stepGate,
  output logic       serGate,
  output logic       ready
);
  logic inRst;
  logic inRstPrev;
  logic inSlp;
  logic rstReq;

  // Sleep masks both reset sources.
  assign rstReq = (uvFlag | resetPin) & sleepN;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      inRst     <= 1'b1;
      inRstPrev <= 1'b0;
      inSlp     <= 1'b0;
    end else begin
      inRst     <= rstReq;
      inRstPrev <= inRst;
      inSlp     <= ~sleepN;
    end
  end

  always_comb begin
    strobe.holdRst = inRst;
    strobe.holdSlp = inSlp;
  end

  assign regClrPulse  = inRst & ~inRstPrev;
  assign powerEn      = ~inRst & ~inSlp & ~rstBusy;
  assign analogLowPwr = inSlp;
  assign ready        = powerEn & ~slpBusy;
  assign stepGate     = stepIn & ready;
  assign serGate      = serAccReq & ~inRst;
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_DIV = 1000
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic uvFlag,
  input  logic resetPin,
  input  logic sleepN,
  input  logic stepIn,
  input  logic serAccReq,
  output logic regClrPulse,
  output logic powerEn,
  output logic analogLowPwr,
  output logic stepGate,
  output logic serGate,
  output logic ready
);
  localparam int unsigned WAIT_RAW = CLK_HZ / SETTLE_DIV;
  localparam int unsigned WAIT     = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  seqStrobe_t strobe;
  logic       rstBusy;
  logic       slpBusy;

  pwrseq_ctrl ctrl_i (
    .clk(clk), .sysRstN(sysRstN), .uvFlag(uvFlag), .resetPin(resetPin),
    .sleepN(sleepN), .stepIn(stepIn), .serAccReq(serAccReq),
    .rstBusy(rstBusy), .slpBusy(slpBusy), .strobe(strobe),
    .regClrPulse(regClrPulse), .powerEn(powerEn), .analogLowPwr(analogLowPwr),
    .stepGate(stepGate), .serGate(serGate), .ready(ready)
  );

  pwrseq_timer #(.WAIT(WAIT)) timer_i (
    .clk(clk), .sysRstN(sysRstN), .strobe(strobe),
    .rstBusy(rstBusy), .slpBusy(slpBusy)
  );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic clk,
  input logic sysRstN,
  input logic uvFlag,
  input logic resetPin,
  input logic sleepN,
  input logic stepIn,
  input logic serAccReq,
  input logic regClrPulse,
  input logic powerEn,
  input logic analogLowPwr,
  input logic stepGate,
  input logic serGate,
  input logic ready
);
  // R1
  rst_blocks_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    ((uvFlag | resetPin) & sleepN) |=> (!powerEn && !ready && !serGate && !stepGate));

  // R2
  clr_single_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    regClrPulse |=> !regClrPulse);

  // R4
  sleep_state_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !sleepN |=> (analogLowPwr && !powerEn && !ready));

  // R5
  sleep_masks_rst_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !sleepN |=> (!regClrPulse && (serGate == serAccReq)));

  // R3
  ser_in_sleep_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    analogLowPwr |-> (serGate == serAccReq));

  // R8
  step_gate_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    stepGate |-> (stepIn && ready && powerEn && !analogLowPwr));
endmodule

bind pwrseq_top pwrseq_chk chk_i (
  .clk(clk), .sysRstN(sysRstN), .uvFlag(uvFlag), .resetPin(resetPin),
  .sleepN(sleepN), .stepIn(stepIn), .serAccReq(serAccReq),
  .regClrPulse(regClrPulse), .powerEn(powerEn), .analogLowPwr(analogLowPwr),
  .stepGate(stepGate), .serGate(serGate), .ready(ready)
);

// File: tb/pwrseq_tb.sv
module pwrseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int W          = CLK_HZ / 1000;  // 8 cycles

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic uvFlag = 1'b0, resetPin = 1'b0, sleepN = 1'b1, stepIn = 1'b0, serAccReq = 1'b0;
  logic regClrPulse, powerEn, analogLowPwr, stepGate, serGate, ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit mInRst, mPrev, mSlp;
  int mRc, mSc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_top #(.CLK_HZ(CLK_HZ), .SETTLE_DIV(1000)) dut_i (
    .clk(clk), .sysRstN(sysRstN), .uvFlag(uvFlag), .resetPin(resetPin),
    .sleepN(sleepN), .stepIn(stepIn), .serAccReq(serAccReq),
    .regClrPulse(regClrPulse), .powerEn(powerEn), .analogLowPwr(analogLowPwr),
    .stepGate(stepGate), .serGate(serGate), .ready(ready)
  );

  function automatic bit expReady();
    return !mInRst && !mSlp && mRc == 0 && mSc == 0;
  endfunction
  function automatic bit expPowerEn();
    return !mInRst && !mSlp && mRc == 0;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk(regClrPulse, mInRst && !mPrev, "R2", "regClrPulse");
    chk(powerEn, expPowerEn(), "R6", "powerEn");
    chk(analogLowPwr, mSlp, "R4", "analogLowPwr");
    chk(ready, expReady(), "R8", "ready");
    chk(stepGate, stepIn && expReady(), "R7", "stepGate");
    chk(serGate, serAccReq && !mInRst, "R3", "serGate");
  endtask

  function automatic void modelReset();
    mInRst = 1; mPrev = 0; mSlp = 0; mRc = W; mSc = 0;
  endfunction

  function automatic void modelStep();
    int nRc, nSc;
    nRc = mInRst ? W : (mRc > 0 ? mRc - 1 : 0);
    nSc = mSlp ? W : (mSc > 0 ? mSc - 1 : 0);
    mPrev  = mInRst;
    mInRst = (uvFlag | resetPin) & sleepN;
    mSlp   = !sleepN;
    mRc = nRc; mSc = nSc;
  endfunction

  // inputs already set after a negedge; check, clock, return at next negedge
  task automatic cycle();
    #1 checkAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process_rand_seed: begin
      int unused;
      unused = $urandom(32'h5EED_1234);
    end
    modelReset();
    repeat (3) @(negedge clk);
    // reset state of the sequencer: starts in reset (R1, R2)
    #1 checkAll();
    chk(powerEn, 1'b0, "R1", "powerEn in startup reset");
    @(negedge clk);
    sysRstN = 1'b1;

    // directed: startup wait expires (R6, R8)
    stepIn = 1; serAccReq = 1;
    for (int i = 0; i < W + 3; i++) cycle();
    chk(stepGate, 1'b1, "R8", "step passes when ready");

    // directed: reset pin (R1, R2)
    resetPin = 1; cycle();
    chk(regClrPulse, 1'b1, "R2", "pulse on reset entry");
    chk(serGate, 1'b0, "R1", "serial blocked in reset");
    cycle(); cycle();

    // directed: sleep while reset held -> reset ignored (R5)
    sleepN = 0; cycle();
    chk(analogLowPwr, 1'b1, "R4", "low power in sleep");
    chk(serGate, 1'b1, "R5", "serial open in sleep despite reset");
    for (int i = 0; i < 4; i++) cycle();
    // leave sleep with reset still held: takes effect next cycle (R5)
    sleepN = 1; cycle();
    chk(regClrPulse, 1'b1, "R5", "reset acts after sleep exit");
    resetPin = 0; cycle();
    for (int i = 0; i < W + 2; i++) cycle();
    chk(ready, 1'b1, "R6", "ready after waits");

    // directed: undervoltage acts like reset (R1)
    uvFlag = 1; cycle();
    chk(regClrPulse, 1'b1, "R1", "undervoltage causes reset");
    uvFlag = 0;
    for (int i = 0; i < 3; i++) cycle();
    // sleep inside the reset wait (R6, R7)
    sleepN = 0;
    for (int i = 0; i < 3; i++) cycle();
    sleepN = 1;
    for (int i = 0; i < W + 2; i++) cycle();
    chk(ready, 1'b1, "R7", "ready after sleep wait");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 59) == 0) uvFlag = ~uvFlag;
      if ($urandom_range(0, 29) == 0) resetPin = ~resetPin;
      if ($urandom_range(0, 34) == 0) sleepN = ~sleepN;
      stepIn = $urandom_range(0, 1);
      serAccReq = $urandom_range(0, 1);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule